// File: doc/BRIEF.md
# Level-Sensitive Interrupt Source Gateway

This block is the per-source front end of a platform interrupt controller. Each level-sensitive source line has three state bits: pending, claimed and deferred. They are packed 32 sources to a word. Every rising clock edge samples the source lines. A high line on a source that is not in service raises its pending bit. A high line on a source that has been claimed but not yet completed is recorded only in the deferred bit. The interrupt handler's completion then turns that deferred bit back into a pending request.

The arbitration stage sits downstream and sees only the registered pending and claimed vectors. It issues a claim strobe with the winning source ID. Later it issues a completion strobe with the same ID. A claim and a completion may arrive in the same cycle. Priority, enable masking, the register map and edge-triggered sources are handled elsewhere.

Top module: `irq_gateway`

## Requirements
- R1: With the default of 80 sources, state is held in three 32-bit words. Source n maps to bit n of the flat `pend_o` / `claim_o` vectors, which is word n/32, bit n%32. Bits 80 to 95 always read 0.
- R2: A synchronous active-high reset clears all pending, claimed and deferred bits. `pend_o` and `claim_o` are all zero in the cycle after reset is sampled.
- R3: A source line sampled high while its source is not claimed sets its pending bit. The change is visible one cycle after the sampling edge.
- R4: A pending bit stays set after its line falls, until a claim for that source.
- R5: A claim strobe for a valid ID n clears pending bit n and sets claimed bit n on the next edge.
- R6: While source n is claimed, a high line on n leaves pending bit n clear. The line level is held in the deferred bit, so pending and claimed are never both set for one source.
- R7: A completion for a claimed ID n clears claimed bit n. If the deferred bit of n was set at that edge, pending bit n is set again. This holds even when the line falls in the completion cycle.
- R8: A low line sample clears the deferred bit. A source whose line fell before its completion is not re-raised by that completion.
- R9: A completion for an ID whose claimed bit is clear changes no state.
- R10: Source 0 is reserved. Its line is ignored, and it never becomes pending or claimed. Claims or completions carrying ID 0 or an ID of 80 or above have no effect.
- R11: A claim and a completion for different IDs in the same cycle both take effect.
- R12: A claim and a completion for the same ID in the same cycle leave that source claimed and not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | 80 | Level-sensitive source lines, bit n is source n |
| claim_vld_i | input | 1 | Claim strobe |
| claim_id_i | input | 7 | Source ID being claimed |
| done_vld_i | input | 1 | Completion strobe |
| done_id_i | input | 7 | Source ID being completed |
| pend_o | output | 96 | Pending vector, three packed 32-bit words |
| claim_o | output | 96 | Claimed vector, three packed 32-bit words |

## Verification
A corrupted pending or claimed bit appears on `pend_o` or `claim_o` one cycle after the edge that caused it. The bench compares complete vectors, so a wrong bit anywhere in the three words is caught.

The deferred bit has no port of its own. It becomes visible only at a completion. The sweep therefore drops the line in the same cycle as the completion, and separately drops it a cycle before. This gives two outcomes that a missing or stale deferred bit cannot both satisfy.

Every ID from 1 to 79 runs the same sequence. A decode or packing fault confined to one word or one bit position is caught within that ID's pass.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

    localparam int unsigned WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] pend;
        logic [WORD_W-1:0] claimed;
        logic [WORD_W-1:0] defer;
    } gw_word_t;

    // Bits of one packed word that belong to a real, non-reserved source.
    function automatic logic [WORD_W-1:0] live_mask(int unsigned base, int unsigned nsrc);
        logic [WORD_W-1:0] m;
        for (int unsigned i = 0; i < WORD_W; i++) begin
            m[i] = ((base + i) != 0) && ((base + i) < nsrc);
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_gw_id_decode.sv
module irq_gw_id_decode #(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned ID_W    = 7,
    parameter int unsigned FLAT_W  = 96
) (
    input  logic              vld_i,
    input  logic [ID_W-1:0]   id_i,
    output logic [FLAT_W-1:0] hit_o
);

    for (genvar k = 0; k < FLAT_W; k++) begin : g_bit
        if (k != 0 && k < NUM_SRC) begin : g_live
            assign hit_o[k] = vld_i && (id_i == ID_W'(k));
        end else begin : g_dead
            assign hit_o[k] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_gw_word.sv
module irq_gw_word
    import irq_gw_pkg::*;
#(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned BASE    = 0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [WORD_W-1:0] src_i,
    input  logic [WORD_W-1:0] claim_hit_i,
    input  logic [WORD_W-1:0] done_hit_i,
    output logic [WORD_W-1:0] pend_o,
    output logic [WORD_W-1:0] claim_o
);

    localparam logic [WORD_W-1:0] LIVE = live_mask(BASE, NUM_SRC);

    gw_word_t          st_d, st_q;
    logic [WORD_W-1:0] done_ok;
    logic [WORD_W-1:0] busy;

    always_comb begin
        st_d    = st_q;
        // a completion only counts for a source that is actually in service
        done_ok = done_hit_i & st_q.claimed;
        // still in service after this edge's completions
        busy    = st_q.claimed & ~done_ok;

        st_d.pend    = (st_q.pend | (src_i & ~busy) | (done_ok & st_q.defer))
                       & ~claim_hit_i & LIVE;
        st_d.claimed = (busy | claim_hit_i) & LIVE;
        st_d.defer   = src_i & busy & LIVE;

        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign pend_o  = st_q.pend;
    assign claim_o = st_q.claimed;

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
    import irq_gw_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 80,
    parameter int unsigned ID_W      = $clog2(NUM_SRC),
    parameter int unsigned NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W,
    parameter int unsigned FLAT_W    = NUM_WORDS * WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic              claim_vld_i,
    input  logic [ID_W-1:0]   claim_id_i,
    input  logic              done_vld_i,
    input  logic [ID_W-1:0]   done_id_i,
    output logic [FLAT_W-1:0] pend_o,
    output logic [FLAT_W-1:0] claim_o
);

    logic [FLAT_W-1:0] src_flat;
    logic [FLAT_W-1:0] claim_hit;
    logic [FLAT_W-1:0] done_hit;

    assign src_flat = FLAT_W'(src_i);

    irq_gw_id_decode #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W),
        .FLAT_W  (FLAT_W)
    ) u_claim_dec (
        .vld_i (claim_vld_i),
        .id_i  (claim_id_i),
        .hit_o (claim_hit)
    );

    irq_gw_id_decode #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W),
        .FLAT_W  (FLAT_W)
    ) u_done_dec (
        .vld_i (done_vld_i),
        .id_i  (done_id_i),
        .hit_o (done_hit)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        irq_gw_word #(
            .NUM_SRC (NUM_SRC),
            .BASE    (w * WORD_W)
        ) u_word (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .src_i       (src_flat [w*WORD_W +: WORD_W]),
            .claim_hit_i (claim_hit[w*WORD_W +: WORD_W]),
            .done_hit_i  (done_hit [w*WORD_W +: WORD_W]),
            .pend_o      (pend_o   [w*WORD_W +: WORD_W]),
            .claim_o     (claim_o  [w*WORD_W +: WORD_W])
        );
    end

endmodule

// File: rtl/irq_gateway_checker.sv
module irq_gateway_checker #(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned ID_W    = 7,
    parameter int unsigned FLAT_W  = 96
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              claim_vld_i,
    input logic [ID_W-1:0]   claim_id_i,
    input logic              done_vld_i,
    input logic [ID_W-1:0]   done_id_i,
    input logic [FLAT_W-1:0] pend_o,
    input logic [FLAT_W-1:0] claim_o
);

    localparam logic [FLAT_W-1:0] DEAD = ~((FLAT_W'(1) << NUM_SRC) - FLAT_W'(1)) | FLAT_W'(1);

    logic            seen_claim;
    logic [ID_W-1:0] seen_claim_id;
    logic            seen_done;
    logic [ID_W-1:0] seen_done_id;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seen_claim    <= 1'b0;
            seen_claim_id <= '0;
            seen_done     <= 1'b0;
            seen_done_id  <= '0;
        end else begin
            seen_claim    <= claim_vld_i && claim_id_i != 0 && 32'(claim_id_i) < NUM_SRC;
            seen_claim_id <= claim_id_i;
            seen_done     <= done_vld_i && done_id_i != 0 && 32'(done_id_i) < NUM_SRC
                             && claim_o[done_id_i] && !(claim_vld_i && claim_id_i == done_id_i);
            seen_done_id  <= done_id_i;
        end
    end

    p_dead_bits_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        ((pend_o | claim_o) & DEAD) == '0);

    p_claim_takes_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        seen_claim |-> (claim_o[seen_claim_id] && !pend_o[seen_claim_id]));

    p_done_frees_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        seen_done |-> !claim_o[seen_done_id]);

    p_exclusive_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_o & claim_o) == '0);

    p_sticky_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !claim_vld_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

    p_idle_done_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_vld_i && !claim_o[done_id_i] && !claim_vld_i) |=> $stable(claim_o));

endmodule

bind irq_gateway irq_gateway_checker #(
    .NUM_SRC (NUM_SRC),
    .ID_W    (ID_W),
    .FLAT_W  (FLAT_W)
) u_irq_gateway_checker (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .claim_vld_i (claim_vld_i),
    .claim_id_i  (claim_id_i),
    .done_vld_i  (done_vld_i),
    .done_id_i   (done_id_i),
    .pend_o      (pend_o),
    .claim_o     (claim_o)
);

// File: tb/irq_gateway_bench.sv
module irq_gateway_bench;

    localparam int unsigned NSRC   = 80;
    localparam int unsigned IDW    = 7;
    localparam int unsigned VW     = 96;
    localparam time         CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst;
    logic [NSRC-1:0] src;
    logic            claim_vld;
    logic [IDW-1:0]  claim_id;
    logic            done_vld;
    logic [IDW-1:0]  done_id;
    logic [VW-1:0]   pend;
    logic [VW-1:0]   clmd;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_gateway u_irq_gateway (
        .clk_i       (clk),
        .rst_i       (rst),
        .src_i       (src),
        .claim_vld_i (claim_vld),
        .claim_id_i  (claim_id),
        .done_vld_i  (done_vld),
        .done_id_i   (done_id),
        .pend_o      (pend),
        .claim_o     (clmd)
    );

    function automatic logic [VW-1:0] bit_of(int n);
        return VW'(1) << n;
    endfunction

    task automatic chk(string req, logic [VW-1:0] exp_p, logic [VW-1:0] exp_c);
        checks++;
        if (pend !== exp_p || clmd !== exp_c) begin
            failures++;
            $display("FAIL %s pend=%h claim=%h expected pend=%h claim=%h",
                     req, pend, clmd, exp_p, exp_c);
        end
    endtask

    // apply the currently driven inputs across one rising edge, then release strobes
    task automatic step();
        @(negedge clk);
        claim_vld = 1'b0;
        done_vld  = 1'b0;
    endtask

    task automatic do_claim(int n);
        claim_vld = 1'b1;
        claim_id  = IDW'(n);
    endtask

    task automatic do_done(int n);
        done_vld = 1'b1;
        done_id  = IDW'(n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [VW-1:0] all_live;
        rst = 1'b1; src = '0; claim_vld = 1'b0; claim_id = '0; done_vld = 1'b0; done_id = '0;
        @(negedge clk);
        step();
        chk("R2 reset state", '0, '0);
        rst = 1'b0;
        step();

        // per-ID sweep covering R1, R3..R9
        for (int n = 1; n < NSRC; n++) begin
            src[n] = 1'b1;                  step(); chk("R3 set pending", bit_of(n), '0);
            src[n] = 1'b0;                  step(); chk("R4 pending sticky", bit_of(n), '0);
            do_claim(n);                    step(); chk("R5 claim", '0, bit_of(n));
            src[n] = 1'b1;                  step(); chk("R6 deferred while claimed", '0, bit_of(n));
            src[n] = 1'b0; do_done(n);      step(); chk("R7 re-raise on completion", bit_of(n), '0);
            do_claim(n);                    step(); chk("R5 reclaim", '0, bit_of(n));
            src[n] = 1'b1;                  step(); chk("R6 held high", '0, bit_of(n));
            src[n] = 1'b0;                  step(); chk("R8 line fell", '0, bit_of(n));
            do_done(n);                     step(); chk("R8 no re-raise", '0, '0);
            src[n] = 1'b1;                  step();
            src[n] = 1'b0; do_done(n);      step(); chk("R9 idle completion", bit_of(n), '0);
            do_claim(n);                    step();
            do_done(n);                     step(); chk("R1 clean after pass", '0, '0);
        end

        // R10: reserved source and out-of-range IDs
        src[0] = 1'b1;                      step(); chk("R10 source 0 line", '0, '0);
        src[0] = 1'b0; do_claim(0);         step(); chk("R10 claim id 0", '0, '0);
        for (int id = NSRC; id < 128; id++) begin
            do_claim(id); do_done(id);      step(); chk("R10 out-of-range id", '0, '0);
        end

        // R1: every live source at once lands in its packed position
        all_live = ((VW'(1) << NSRC) - VW'(1)) & ~VW'(1);
        src = '1;                           step(); chk("R1 all sources", all_live, '0);
        src = '0;                           step();
        for (int n = 1; n < NSRC; n++) begin
            do_claim(n); step();
        end
        chk("R1 all claimed", '0, all_live);
        for (int n = 1; n < NSRC; n++) begin
            do_done(n); step();
        end
        chk("R1 all completed", '0, '0);

        // R11: claim 9 and complete 5 together
        src[9] = 1'b1; do_claim(5);         step();
        src[9] = 1'b0;                      step(); chk("R11 setup", bit_of(9), bit_of(5));
        do_claim(9); do_done(5);            step(); chk("R11 independent", '0, bit_of(9));
        do_done(9);                         step();

        // R12: same ID claimed and completed together while deferred
        do_claim(40);                       step();
        src[40] = 1'b1;                     step();
        do_claim(40); do_done(40);          step(); chk("R12 claim wins", '0, bit_of(40));
        src[40] = 1'b0;                     step();
        do_done(40);                        step(); chk("R12 cleanup", '0, '0);

        // R2: reset mid-run clears live state
        src[70] = 1'b1; do_claim(33);       step();
        rst = 1'b1;                         step(); chk("R2 mid-run reset", '0, '0);
        rst = 1'b0; src = '0;               step(); chk("R2 after reset", '0, '0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule